// File: doc/BRIEF.md
# Segmented Word Access Splitter

This block turns real-mode `segment:offset` memory requests into single-byte cycles on an 8-bit bus with a 20-bit physical address space. It holds one base register for each of the four segments. Each base is the 16-bit segment value with four zero bits appended. A request names a segment, a 16-bit offset, an access kind and a width. The block forms the physical address and runs one bus handshake for each byte.

A word access always moves two bytes, and the low byte goes first. The high-byte address follows the two wrap rules of a real-mode machine. If the offset is at the end of the segment, the high byte comes from offset zero of the same segment. If the low byte sits at the top of physical memory, the high byte comes from physical address zero.

Word writes and read-modify-write words are not finished when the request is accepted. The block latches both byte addresses and waits for a write-back value. It then stores that value at exactly those two addresses. No new request is accepted until the write-back completes.

Top module: `seg_word_splitter`

## Requirements
- R1: After reset the CS base is 0xFFFF0 and the ES, SS and DS bases are 0. `req_ready_o` is high, and `bus_valid_o`, `rsp_valid_o` and `wb_ready_o` are low.
- R2: A segment write (`seg_we_i` high for one cycle) sets the selected base to `{seg_val_i, 4'h0}`. Requests accepted after that cycle use the new base.
- R3: Segment selector codes are 0 = ES, 1 = CS and 2 = SS. Every other code from 3 to 7 selects DS. This applies to segment writes and to requests alike.
- R4: The low-byte physical address is (base + offset) modulo 2^20.
- R5: A word read runs two read cycles, first at the low address and then at the high address. Normally the high address is the low address plus 1. The response carries `{high byte, low byte}`.
- R6: At offset 0xFFFF, the high byte of a word is read from or written to offset 0 of the same segment, which is the base itself. This rule takes precedence over R7.
- R7: When the low-byte physical address is 0xFFFFF and the offset is not 0xFFFF, the high byte of a word is at physical address 0x00000.
- R8: Kind codes are 0 = read, 1 = write and 2 = read-modify-write; code 3 acts as a read. A byte read, or a byte read-modify-write, runs one read cycle and responds with `{8'h00, byte}`, and no write-back follows. A byte write runs one write cycle carrying `req_wdata_i` and gives no response.
- R9: A read-modify-write word reads both bytes and responds. It then raises `wb_ready_o`. An accepted write-back writes `wb_data_i[7:0]` to the low address and then `wb_data_i[15:8]` to the high address.
- R10: A word write runs no bus cycle before its write-back. The write-back stores the value at the two latched addresses, low byte first.
- R11: From the acceptance of a word write or read-modify-write word until the last write-back byte completes, `req_ready_o` stays low and no request is accepted. When the write-back completes, the block returns to idle.
- R12: `wb_valid_i` has no effect while `wb_ready_o` is low. While `bus_valid_o` is high and `bus_ready_i` is low, the bus outputs hold steady.
- R13: `rsp_valid_o` is a one-cycle pulse in the cycle after the final read handshake of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_we_i | input | 1 | Segment register write strobe |
| seg_sel_i | input | 3 | Segment selector for the write |
| seg_val_i | input | 16 | New segment value |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_seg_i | input | 3 | Segment selector for the request |
| req_off_i | input | 16 | Offset within the segment |
| req_kind_i | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_word_i | input | 1 | 1 for a word access, 0 for a byte access |
| req_wdata_i | input | 8 | Data for a byte write |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_data_o | output | 16 | Read data, high byte in bits 15:8 |
| wb_valid_i | input | 1 | Write-back value valid |
| wb_ready_o | output | 1 | Block is waiting for a write-back value |
| wb_data_i | input | 16 | Write-back value |
| bus_valid_o | output | 1 | Byte cycle request |
| bus_ready_i | input | 1 | Byte cycle completes when high with valid |
| bus_addr_o | output | 20 | Physical byte address |
| bus_we_o | output | 1 | 1 for a write cycle |
| bus_wdata_o | output | 8 | Write byte |
| bus_rdata_i | input | 8 | Read byte, sampled at the handshake |

## Verification
The bench targets the two wrap cases and the point where they meet. These are a word at offset 0xFFFF, a word whose low byte lands on 0xFFFFF, and a word where both conditions hold. A design that carries the offset into the next linear address, or that gives the physical wrap priority, would put the high-byte cycle at the wrong address. It also covers a base that overflows 20 bits and selector codes above 2, where a wrong decode would read from a stale base. Write-back is checked for both a word write and a read-modify-write word with bus stalls applied. A design that accepted a new request while a write-back was pending, acted on a stray write-back strobe, or wrote back to freshly computed addresses would produce bus cycles that the scoreboard does not expect.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEL_W  = 3;
  localparam int NSEG   = 4;
  localparam int IDX_ES = 0;
  localparam int IDX_CS = 1;
  localparam int IDX_SS = 2;
  localparam int IDX_DS = 3;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_RMW   = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_WR_BYTE, ST_WAIT_WB, ST_WB_LO, ST_WB_HI
  } st_e;

  // codes above SS fall through to DS
  function automatic logic [1:0] seg_idx(logic [SEL_W-1:0] sel);
    return (sel < SEL_W'(IDX_DS)) ? sel[1:0] : 2'(IDX_DS);
  endfunction
endpackage

// File: rtl/seg_base_regs.sv
module seg_base_regs
  import seg_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic [SEG_W-1:0]  wval_i,
  input  logic [SEL_W-1:0]  rsel_i,
  output logic [ADDR_W-1:0] rbase_o
);
  localparam int SHIFT = ADDR_W - SEG_W;
  localparam logic [ADDR_W-1:0] CS_RESET = {{SEG_W{1'b1}}, {SHIFT{1'b0}}};

  logic [ADDR_W-1:0] base_q [NSEG];
  logic [1:0]        widx;

  assign widx = seg_idx(wsel_i);

  for (genvar g = 0; g < NSEG; g++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      base_q[g] <= (g == IDX_CS) ? CS_RESET : '0;
      else if (we_i && widx == 2'(g))   base_q[g] <= {wval_i, {SHIFT{1'b0}}};
    end
  end

  assign rbase_o = base_q[seg_idx(rsel_i)];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  logic seg_wrap, phys_wrap;

  assign lo_o      = base_i + ADDR_W'(off_i);
  assign seg_wrap  = &off_i;
  assign phys_wrap = &lo_o;

  // segment-end wrap wins over top-of-memory wrap
  always_comb begin
    if (seg_wrap)       hi_o = base_i;
    else if (phys_wrap) hi_o = '0;
    else                hi_o = lo_o + ADDR_W'(1);
  end
endmodule

// File: rtl/seg_seq.sv
module seg_seq
  import seg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [1:0]          req_kind_i,
  input  logic                req_word_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [ADDR_W-1:0]   addr_lo_i,
  input  logic [ADDR_W-1:0]   addr_hi_i,
  output logic                rsp_valid_o,
  output logic [2*DATA_W-1:0] rsp_data_o,
  input  logic                wb_valid_i,
  output logic                wb_ready_o,
  input  logic [2*DATA_W-1:0] wb_data_i,
  output logic                bus_valid_o,
  input  logic                bus_ready_i,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic                bus_we_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic [DATA_W-1:0]   bus_rdata_i
);
  st_e                 st_q;
  logic [ADDR_W-1:0]   lo_q, hi_q;
  logic                word_q, rmw_q;
  logic [DATA_W-1:0]   byte_q, rd_lo_q;
  logic [2*DATA_W-1:0] wb_q;
  logic                done;

  assign req_ready_o = (st_q == ST_IDLE);
  assign wb_ready_o  = (st_q == ST_WAIT_WB);
  assign bus_valid_o = !(st_q inside {ST_IDLE, ST_WAIT_WB});
  assign bus_we_o    = st_q inside {ST_WR_BYTE, ST_WB_LO, ST_WB_HI};
  assign bus_addr_o  = (st_q inside {ST_RD_HI, ST_WB_HI}) ? hi_q : lo_q;
  assign done        = bus_valid_o && bus_ready_i;

  always_comb begin
    unique case (st_q)
      ST_WB_LO: bus_wdata_o = wb_q[DATA_W-1:0];
      ST_WB_HI: bus_wdata_o = wb_q[2*DATA_W-1:DATA_W];
      default:  bus_wdata_o = byte_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      lo_q        <= '0;
      hi_q        <= '0;
      word_q      <= 1'b0;
      rmw_q       <= 1'b0;
      byte_q      <= '0;
      rd_lo_q     <= '0;
      wb_q        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          lo_q   <= addr_lo_i;
          hi_q   <= addr_hi_i;
          word_q <= req_word_i;
          rmw_q  <= (req_kind_i == KIND_RMW);
          byte_q <= req_wdata_i;
          if (req_kind_i == KIND_WRITE) st_q <= req_word_i ? ST_WAIT_WB : ST_WR_BYTE;
          else                          st_q <= ST_RD_LO;
        end
        ST_RD_LO: if (done) begin
          rd_lo_q <= bus_rdata_i;
          if (word_q) st_q <= ST_RD_HI;
          else begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= {{DATA_W{1'b0}}, bus_rdata_i};
            st_q        <= ST_IDLE;
          end
        end
        ST_RD_HI: if (done) begin
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= {bus_rdata_i, rd_lo_q};
          st_q        <= rmw_q ? ST_WAIT_WB : ST_IDLE;
        end
        ST_WR_BYTE: if (done) st_q <= ST_IDLE;
        ST_WAIT_WB: if (wb_valid_i) begin
          wb_q <= wb_data_i;
          st_q <= ST_WB_LO;
        end
        ST_WB_LO: if (done) st_q <= ST_WB_HI;
        ST_WB_HI: if (done) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_word_splitter.sv
module seg_word_splitter
  import seg_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                seg_we_i,
  input  logic [SEL_W-1:0]    seg_sel_i,
  input  logic [SEG_W-1:0]    seg_val_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [SEL_W-1:0]    req_seg_i,
  input  logic [SEG_W-1:0]    req_off_i,
  input  logic [1:0]          req_kind_i,
  input  logic                req_word_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [2*DATA_W-1:0] rsp_data_o,
  input  logic                wb_valid_i,
  output logic                wb_ready_o,
  input  logic [2*DATA_W-1:0] wb_data_i,
  output logic                bus_valid_o,
  input  logic                bus_ready_i,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic                bus_we_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic [DATA_W-1:0]   bus_rdata_i
);
  logic [ADDR_W-1:0] base, addr_lo, addr_hi;

  seg_base_regs #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) i_base (
    .clk_i, .rst_ni,
    .we_i(seg_we_i), .wsel_i(seg_sel_i), .wval_i(seg_val_i),
    .rsel_i(req_seg_i), .rbase_o(base)
  );

  seg_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(SEG_W)) i_agen (
    .base_i(base), .off_i(req_off_i), .lo_o(addr_lo), .hi_o(addr_hi)
  );

  seg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_kind_i, .req_word_i, .req_wdata_i,
    .addr_lo_i(addr_lo), .addr_hi_i(addr_hi),
    .rsp_valid_o, .rsp_data_o,
    .wb_valid_i, .wb_ready_o, .wb_data_i,
    .bus_valid_o, .bus_ready_i, .bus_addr_o, .bus_we_o, .bus_wdata_o, .bus_rdata_i
  );
endmodule

// File: rtl/seg_word_splitter_chk.sv
module seg_word_splitter_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              wb_valid_i,
  input logic              wb_ready_o,
  input logic              bus_valid_o,
  input logic              bus_ready_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_we_o,
  input logic [DATA_W-1:0] bus_wdata_o
);
  a_r12_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
                                    && $stable(bus_we_o) && $stable(bus_wdata_o));

  a_r11_no_accept_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ready_o |-> !req_ready_o);

  a_r10_quiet_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ready_o |-> !bus_valid_o);

  a_r13_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r9_wb_starts_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ready_o && wb_valid_i |=> bus_valid_o && bus_we_o);

  a_r1_idle_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_valid_o && !wb_ready_o);
endmodule

bind seg_word_splitter seg_word_splitter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .wb_valid_i(wb_valid_i), .wb_ready_o(wb_ready_o), .bus_valid_o(bus_valid_o),
  .bus_ready_i(bus_ready_i), .bus_addr_o(bus_addr_o), .bus_we_o(bus_we_o),
  .bus_wdata_o(bus_wdata_o)
);

// File: tb/test_seg_word_splitter.sv
module test_seg_word_splitter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seg_we_i = 1'b0;
  logic [2:0]  seg_sel_i = '0;
  logic [15:0] seg_val_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [2:0]  req_seg_i = '0;
  logic [15:0] req_off_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        req_word_i = 1'b0;
  logic [7:0]  req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [15:0] rsp_data_o;
  logic        wb_valid_i = 1'b0;
  logic        wb_ready_o;
  logic [15:0] wb_data_i = '0;
  logic        bus_valid_o;
  logic        bus_ready_i = 1'b1;
  logic [19:0] bus_addr_o;
  logic        bus_we_o;
  logic [7:0]  bus_wdata_o;
  logic [7:0]  bus_rdata_i;

  int n_run = 0, n_fail = 0;
  logic        stall_en = 1'b0;
  logic [1:0]  rc = '0;
  logic [19:0] mb [4];
  logic [19:0] pend_lo, pend_hi;
  logic [28:0] exp_bus [$];
  string       exp_bus_tag [$];
  logic [15:0] exp_rsp [$];
  string       exp_rsp_tag [$];

  seg_word_splitter i_seg_word_splitter (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] pat(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  assign bus_rdata_i = pat(bus_addr_o);

  function automatic int bidx(logic [2:0] s);
    return (s < 3'd3) ? int'(s) : 3;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    rc <= rc + 2'd1;
    bus_ready_i <= stall_en ? (rc != 2'd1) : 1'b1;
  end

  // monitor: values seen here are those present at the next rising edge
  always begin
    @(negedge clk_i); #1;
    if (rst_ni) begin
      if (bus_valid_o && bus_ready_i) begin
        if (exp_bus.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R11 unexpected bus cycle actual=%h expected=none", {bus_we_o, bus_addr_o});
        end else begin
          logic [28:0] e;
          string t;
          e = exp_bus.pop_front();
          t = exp_bus_tag.pop_front();
          chk(bus_we_o == e[28] && bus_addr_o == e[27:8] && (!e[28] || bus_wdata_o == e[7:0]),
              t, {3'b0, bus_we_o, bus_addr_o, bus_wdata_o}, {3'b0, e});
        end
      end
      if (rsp_valid_o) begin
        if (exp_rsp.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R13 unexpected response actual=%h expected=none", rsp_data_o);
        end else begin
          logic [15:0] d;
          string t;
          d = exp_rsp.pop_front();
          t = exp_rsp_tag.pop_front();
          chk(rsp_data_o == d, t, 32'(rsp_data_o), 32'(d));
        end
      end
    end
  end

  task automatic seg_write(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_sel_i = s; seg_val_i = v;
    @(negedge clk_i);
    seg_we_i = 1'b0;
    mb[bidx(s)] = {v, 4'h0};
  endtask

  task automatic issue(input logic [2:0] s, input logic [15:0] off, input logic [1:0] kind,
                       input logic word, input logic [7:0] wd, input string tag);
    logic [19:0] b, lo, hi;
    b  = mb[bidx(s)];
    lo = b + {4'h0, off};
    if (off == 16'hFFFF)       hi = b;
    else if (lo == 20'hFFFFF)  hi = '0;
    else                       hi = lo + 20'd1;
    pend_lo = lo; pend_hi = hi;
    if (kind == 2'd1) begin
      if (!word) begin
        exp_bus.push_back({1'b1, lo, wd}); exp_bus_tag.push_back(tag);
      end
    end else begin
      exp_bus.push_back({1'b0, lo, 8'h00}); exp_bus_tag.push_back(tag);
      if (word) begin
        exp_bus.push_back({1'b0, hi, 8'h00}); exp_bus_tag.push_back(tag);
        exp_rsp.push_back({pat(hi), pat(lo)});
      end else begin
        exp_rsp.push_back({8'h00, pat(lo)});
      end
      exp_rsp_tag.push_back(tag);
    end
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_seg_i = s; req_off_i = off;
    req_kind_i = kind; req_word_i = word; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic do_wb(input logic [15:0] v, input string tag);
    exp_bus.push_back({1'b1, pend_lo, v[7:0]});  exp_bus_tag.push_back(tag);
    exp_bus.push_back({1'b1, pend_hi, v[15:8]}); exp_bus_tag.push_back(tag);
    @(negedge clk_i);
    while (!wb_ready_o) @(negedge clk_i);
    wb_valid_i = 1'b1; wb_data_i = v;
    @(negedge clk_i);
    wb_valid_i = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && (exp_bus.size() != 0 || exp_rsp.size() != 0 || !req_ready_o); i++)
      @(negedge clk_i);
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    mb[0] = '0; mb[1] = 20'hFFFF0; mb[2] = '0; mb[3] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 idle state after reset
    chk(req_ready_o == 1'b1, "R1 req_ready", 32'(req_ready_o), 1);
    chk(bus_valid_o == 1'b0 && rsp_valid_o == 1'b0 && wb_ready_o == 1'b0, "R1 outputs quiet",
        {bus_valid_o, rsp_valid_o, wb_ready_o}, 0);
    issue(3'd1, 16'h0000, 2'd0, 1'b0, 8'h00, "R1 CS base FFFF0");
    issue(3'd0, 16'h1234, 2'd0, 1'b0, 8'h00, "R1 ES base zero");
    drain();

    // R12 stray write-back strobe while idle has no effect
    @(negedge clk_i);
    wb_valid_i = 1'b1; wb_data_i = 16'hDEAD;
    @(negedge clk_i);
    wb_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !wb_ready_o, "R12 stray wb ignored", {req_ready_o, wb_ready_o}, 2);

    // R2 R3 base writes and selector decode
    seg_write(3'd0, 16'h1000);
    seg_write(3'd1, 16'h2345);
    seg_write(3'd2, 16'hABCD);
    seg_write(3'd5, 16'h0F00);
    issue(3'd0, 16'h0004, 2'd0, 1'b0, 8'h00, "R2 ES base");
    issue(3'd1, 16'h0004, 2'd0, 1'b0, 8'h00, "R2 CS base");
    issue(3'd2, 16'h0004, 2'd0, 1'b0, 8'h00, "R3 SS code");
    issue(3'd3, 16'h0004, 2'd0, 1'b0, 8'h00, "R3 DS code 3");
    issue(3'd7, 16'h0008, 2'd3, 1'b0, 8'h00, "R3 DS code 7 kind3");

    // R5 R8 word read, byte write, byte rmw
    issue(3'd0, 16'h0010, 2'd0, 1'b1, 8'h00, "R5 word read");
    issue(3'd4, 16'h0020, 2'd1, 1'b0, 8'hA5, "R8 byte write");
    issue(3'd0, 16'h0030, 2'd2, 1'b0, 8'h00, "R8 byte rmw");
    drain();
    chk(!wb_ready_o && req_ready_o, "R8 no write-back after byte rmw", {wb_ready_o, req_ready_o}, 1);

    // R4 base overflow past 20 bits
    seg_write(3'd2, 16'hFFFF);
    issue(3'd2, 16'h0100, 2'd0, 1'b1, 8'h00, "R4 address modulo");
    // R6 segment-end wrap
    issue(3'd3, 16'hFFFF, 2'd0, 1'b1, 8'h00, "R6 offset FFFF");
    // R7 top-of-memory wrap
    seg_write(3'd0, 16'hFFFF);
    issue(3'd0, 16'h000F, 2'd0, 1'b1, 8'h00, "R7 phys FFFFF");
    // R6 over R7 precedence
    seg_write(3'd0, 16'hF000);
    issue(3'd0, 16'hFFFF, 2'd0, 1'b1, 8'h00, "R6 precedence");
    drain();

    // R9 rmw word with stalls
    stall_en = 1'b1;
    issue(3'd2, 16'h0FFF, 2'd2, 1'b1, 8'h00, "R9 rmw read");
    do_wb(16'hBEEF, "R9 write-back");
    issue(3'd0, 16'hFFFF, 2'd2, 1'b1, 8'h00, "R9 rmw wrapped read");
    do_wb(16'h1234, "R9 wrapped write-back");
    drain();

    // R10 R11 word write holds off a new request
    issue(3'd1, 16'h0200, 2'd1, 1'b1, 8'h00, "R10 word write");
    for (int i = 0; i < 5; i++) begin
      req_valid_i = 1'b1; req_seg_i = 3'd0; req_off_i = 16'h0050;
      req_kind_i = 2'd0; req_word_i = 1'b0;
      @(negedge clk_i);
      chk(!req_ready_o && wb_ready_o, "R11 blocked while pending", {req_ready_o, wb_ready_o}, 1);
    end
    req_valid_i = 1'b0;
    do_wb(16'hCAFE, "R10 write-back");
    drain();
    chk(req_ready_o && !wb_ready_o, "R11 idle after write-back", {req_ready_o, wb_ready_o}, 2);
    issue(3'd1, 16'h0201, 2'd0, 1'b1, 8'h00, "R11 accepted after write-back");
    stall_en = 1'b0;
    drain();

    chk(exp_bus.size() == 0, "R13 bus queue empty", 32'(exp_bus.size()), 0);
    chk(exp_rsp.size() == 0, "R13 response queue empty", 32'(exp_rsp.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule